// File: doc/BRIEF.md
# Serial Audio Link Frame Transmitter

This block is the controller-side transmit half of a time-division multiplexed serial audio and control link. It runs on the link's bit clock (nominally 12.288 MHz, roughly 81.4 ns per bit) and emits one 256-bit frame every 256 clocks, giving a 48 kHz frame rate and a frame period of about 20.8 µs. Each frame starts with a 16-bit tag slot, followed by twelve 20-bit data slots. Every data slot is sent most significant bit first.

The tag slot is built from the inputs. Its first bit says whether the frame carries anything. The next twelve bits mark which data slots are valid. Two further bits carry the codec identifier, and the last tag bit is zero. A data slot whose valid flag is clear goes out as all zeros.

A frame marker output goes high for 16 bit times at the start of each frame. The marker rises one bit ahead of the first tag bit, so the partner sees it high while the last bit of the previous frame is still on the data line. All outputs change just after the rising clock edge, so the partner can latch them on the falling edge.

A one-cycle strobe shows when the block takes in new slot contents. Slot words, valid flags, the frame-valid flag and the identifier are sampled only at the rising edge that ends the strobe cycle. They are held in a shadow copy for the whole frame.

Top module: `tdm_frame_tx`

## Requirements
- R1: A frame is 256 bit times long. `frame_start_o` is high for exactly one cycle in every 256, and it is high in the first cycle after reset is released.
- R2: `sync_o` is high for exactly 16 consecutive cycles and then low for 240. It rises at the clock edge that ends a `frame_start_o` cycle. That edge drives bit F255 of the previous frame, so `sync_o` leads bit F0 by one bit time.
- R3: The tag slot occupies F0 to F15 and is laid out as follows. F0 carries `frame_valid_i`. F1 to F12 carry `slot_valid_i[0]` to `slot_valid_i[11]` (the flags for slots 1 to 12). F13 carries `codec_id_i[1]`, F14 carries `codec_id_i[0]`, and F15 is 0.
- R4: Slot n (1 to 12) occupies F(16+20·(n−1)) to F(35+20·(n−1)). It carries `slot_data_i[(n−1)·20 +: 20]`, most significant bit first, so slot 1's bit 19 (the read/write command bit) is F16.
- R5: A slot whose valid flag is 0 is sent as twenty 0 bits, whatever its data input holds.
- R6: Inputs are sampled only at the rising edge that ends a `frame_start_o` cycle. Changes at any other time have no effect on the frame being sent, and take effect in the next frame.
- R7: While `rst` (synchronous, active high) is high, `sync_o`, `sdata_o` and `frame_start_o` are 0 one edge later. The bit counter is cleared, so a new frame begins as soon as reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock; outputs change on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| slot_data_i | input | 240 | Twelve 20-bit slot words; slot n at bits (n−1)·20 +: 20 |
| slot_valid_i | input | 12 | Valid flag per slot; bit n−1 for slot n |
| frame_valid_i | input | 1 | Frame-valid flag sent as tag bit F0 |
| codec_id_i | input | 2 | Codec identifier sent in F13 (bit 1) and F14 (bit 0) |
| frame_start_o | output | 1 | One-cycle strobe; inputs are sampled at the edge ending it |
| sync_o | output | 1 | Frame marker, high for 16 bit times |
| sdata_o | output | 1 | Serial frame data, one bit per clock |

## Verification
Some behaviours are checked by assertions on every cycle. These are the 256-cycle spacing of the start strobe, the 16-cycle width of the frame marker and its rise one edge after the strobe, and the quiet outputs under reset. They also cover the zero padding bit of the tag slot, the forcing of invalid slots to zero, and the stability of the shadow copy between strobes. Whether each serial bit lands at its frame position is shown only by the bench. The bench reassembles whole frames and compares every field of every slot. It also shows the MSB-first order, and that changing the inputs mid-frame leaves the current frame intact.

// File: rtl/tdm_tx_pkg.sv
package tdm_tx_pkg;

   localparam int unsigned DEF_TAG_BITS  = 16;
   localparam int unsigned DEF_SLOTS     = 12;
   localparam int unsigned DEF_SLOT_BITS = 20;
   localparam int unsigned DEF_ID_BITS   = 2;
   localparam int unsigned DEF_SYNC_BITS = 16;

   // Total bit times in one frame.
   function automatic int unsigned frame_len(input int unsigned tag_bits,
                                             input int unsigned slots,
                                             input int unsigned slot_bits);
      return tag_bits + slots * slot_bits;
   endfunction

   // First bit position of data slot idx (0-based).
   function automatic int unsigned slot_first(input int unsigned tag_bits,
                                              input int unsigned slot_bits,
                                              input int unsigned idx);
      return tag_bits + idx * slot_bits;
   endfunction

endpackage

// File: rtl/tdm_frame_counter.sv
module tdm_frame_counter #(
   parameter int unsigned FRAME_BITS = 256,
   parameter int unsigned POS_W      = $clog2(FRAME_BITS)
) (
   input  logic             clk,
   input  logic             rst,
   output logic [POS_W-1:0] pos_o,
   output logic             start_o
);

   localparam logic [POS_W-1:0] LAST = POS_W'(FRAME_BITS - 1);

   always_ff @(posedge clk) begin
      if (rst)                pos_o <= '0;
      else if (pos_o == LAST) pos_o <= '0;
      else                    pos_o <= pos_o + 1'b1;
   end

   assign start_o = !rst && (pos_o == '0);

   // Spacing checker for the start strobe.
   logic [POS_W-1:0] gap_q;
   logic             seen_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         gap_q  <= '0;
         seen_q <= 1'b0;
      end else if (start_o) begin
         gap_q  <= '0;
         seen_q <= 1'b1;
      end else begin
         gap_q  <= gap_q + 1'b1;
      end
   end

   assert_start_period_R1: assert property (@(posedge clk) disable iff (rst)
      (start_o && seen_q) |-> (gap_q == LAST));

   assert_counter_wrap_R1: assert property (@(posedge clk) disable iff (rst)
      (pos_o == LAST) |=> start_o);

endmodule

// File: rtl/tdm_slot_shadow.sv
module tdm_slot_shadow #(
   parameter int unsigned NUM_SLOTS = 12,
   parameter int unsigned SLOT_BITS = 20,
   parameter int unsigned TAG_BITS  = 16,
   parameter int unsigned ID_BITS   = 2
) (
   input  logic                           clk,
   input  logic                           rst,
   input  logic                           load_i,
   input  logic [NUM_SLOTS*SLOT_BITS-1:0] data_i,
   input  logic [NUM_SLOTS-1:0]           valid_i,
   input  logic                           frame_valid_i,
   input  logic [ID_BITS-1:0]             id_i,
   output logic [NUM_SLOTS*SLOT_BITS-1:0] words_o,
   output logic [TAG_BITS-1:0]            tag_o
);

   localparam int unsigned USED_TAG = 1 + NUM_SLOTS + ID_BITS;

   logic [ID_BITS-1:0]             id_rev;
   logic [TAG_BITS-1:0]            tag_next;
   logic [NUM_SLOTS*SLOT_BITS-1:0] words_next;

   // Identifier goes out high bit first, right after the slot flags.
   for (genvar j = 0; j < ID_BITS; j++) begin : g_id
      assign id_rev[j] = id_i[ID_BITS-1-j];
   end

   assign tag_next = TAG_BITS'({id_rev, valid_i, frame_valid_i});

   // Invalid slots are zeroed as they are captured.
   for (genvar k = 0; k < NUM_SLOTS; k++) begin : g_mask
      assign words_next[k*SLOT_BITS +: SLOT_BITS] =
         valid_i[k] ? data_i[k*SLOT_BITS +: SLOT_BITS] : '0;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         words_o <= '0;
         tag_o   <= '0;
      end else if (load_i) begin
         words_o <= words_next;
         tag_o   <= tag_next;
      end
   end

   if (TAG_BITS < USED_TAG) begin : g_bad_tag
      $error("tag slot too narrow for flags and identifier");
   end

   assert_shadow_hold_R6: assert property (@(posedge clk) disable iff (rst)
      !load_i |=> ($stable(words_o) && $stable(tag_o)));

endmodule

// File: rtl/tdm_bit_select.sv
module tdm_bit_select
   import tdm_tx_pkg::*;
#(
   parameter int unsigned NUM_SLOTS = 12,
   parameter int unsigned SLOT_BITS = 20,
   parameter int unsigned TAG_BITS  = 16,
   parameter int unsigned POS_W     = 8
) (
   input  logic [POS_W-1:0]               pos_i,
   input  logic [NUM_SLOTS*SLOT_BITS-1:0] words_i,
   input  logic [TAG_BITS-1:0]            tag_i,
   output logic [NUM_SLOTS-1:0]           hit_o,
   output logic                           bit_o
);

   localparam logic [POS_W-1:0] TAG_P   = POS_W'(TAG_BITS);
   localparam logic [POS_W-1:0] WIDTH_P = POS_W'(SLOT_BITS);

   logic [NUM_SLOTS-1:0] slot_bit;
   logic [TAG_BITS-1:0]  tag_sh;
   logic                 in_tag;

   // One range comparator per slot instead of a divider.
   for (genvar k = 0; k < NUM_SLOTS; k++) begin : g_slot
      localparam logic [POS_W-1:0] FIRST =
         POS_W'(slot_first(TAG_BITS, SLOT_BITS, k));
      logic [POS_W-1:0]     off;
      logic [SLOT_BITS-1:0] sh;
      assign off         = pos_i - FIRST;
      assign hit_o[k]    = off < WIDTH_P;
      assign sh          = words_i[k*SLOT_BITS +: SLOT_BITS] << off;
      assign slot_bit[k] = hit_o[k] & sh[SLOT_BITS-1];
   end

   assign in_tag = pos_i < TAG_P;
   assign tag_sh = tag_i >> pos_i;
   assign bit_o  = (in_tag & tag_sh[0]) | (|slot_bit);

   always_comb begin
      assert_one_region_R4: assert ($onehot0({in_tag, hit_o}));
   end

endmodule

// File: rtl/tdm_frame_tx.sv
module tdm_frame_tx
   import tdm_tx_pkg::*;
#(
   parameter int unsigned NUM_SLOTS = DEF_SLOTS,
   parameter int unsigned SLOT_BITS = DEF_SLOT_BITS,
   parameter int unsigned TAG_BITS  = DEF_TAG_BITS,
   parameter int unsigned ID_BITS   = DEF_ID_BITS,
   parameter int unsigned SYNC_BITS = DEF_SYNC_BITS
) (
   input  logic                           clk,
   input  logic                           rst,
   input  logic [NUM_SLOTS*SLOT_BITS-1:0] slot_data_i,
   input  logic [NUM_SLOTS-1:0]           slot_valid_i,
   input  logic                           frame_valid_i,
   input  logic [ID_BITS-1:0]             codec_id_i,
   output logic                           frame_start_o,
   output logic                           sync_o,
   output logic                           sdata_o
);

   localparam int unsigned FRAME_BITS = frame_len(TAG_BITS, NUM_SLOTS, SLOT_BITS);
   localparam int unsigned POS_W      = $clog2(FRAME_BITS);
   localparam int unsigned USED_TAG   = 1 + NUM_SLOTS + ID_BITS;
   localparam logic [POS_W-1:0] LAST   = POS_W'(FRAME_BITS - 1);
   localparam logic [POS_W-1:0] SYNC_P = POS_W'(SYNC_BITS);

   if (SYNC_BITS < 1 || SYNC_BITS >= FRAME_BITS) begin : g_bad_sync
      $error("marker width must be inside the frame");
   end
   if (SLOT_BITS < 1 || NUM_SLOTS < 1) begin : g_bad_slots
      $error("at least one slot of at least one bit is required");
   end

   logic [POS_W-1:0]               cnt;
   logic [POS_W-1:0]               emit_pos;
   logic [NUM_SLOTS*SLOT_BITS-1:0] words_q;
   logic [TAG_BITS-1:0]            tag_q;
   logic [NUM_SLOTS-1:0]           hit;
   logic                           next_bit;

   tdm_frame_counter #(
      .FRAME_BITS (FRAME_BITS),
      .POS_W      (POS_W)
   ) u_count (
      .clk     (clk),
      .rst     (rst),
      .pos_o   (cnt),
      .start_o (frame_start_o)
   );

   tdm_slot_shadow #(
      .NUM_SLOTS (NUM_SLOTS),
      .SLOT_BITS (SLOT_BITS),
      .TAG_BITS  (TAG_BITS),
      .ID_BITS   (ID_BITS)
   ) u_shadow (
      .clk           (clk),
      .rst           (rst),
      .load_i        (frame_start_o),
      .data_i        (slot_data_i),
      .valid_i       (slot_valid_i),
      .frame_valid_i (frame_valid_i),
      .id_i          (codec_id_i),
      .words_o       (words_q),
      .tag_o         (tag_q)
   );

   // The edge at count 0 still drives the last bit of the old frame,
   // so the data position trails the counter by one.
   assign emit_pos = (cnt == '0) ? LAST : cnt - 1'b1;

   tdm_bit_select #(
      .NUM_SLOTS (NUM_SLOTS),
      .SLOT_BITS (SLOT_BITS),
      .TAG_BITS  (TAG_BITS),
      .POS_W     (POS_W)
   ) u_select (
      .pos_i   (emit_pos),
      .words_i (words_q),
      .tag_i   (tag_q),
      .hit_o   (hit),
      .bit_o   (next_bit)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         sync_o  <= 1'b0;
         sdata_o <= 1'b0;
      end else begin
         sync_o  <= cnt < SYNC_P;
         sdata_o <= next_bit;
      end
   end

   // Marker run-length checker.
   logic [POS_W-1:0] sync_run_q;
   always_ff @(posedge clk) begin
      if (rst)         sync_run_q <= '0;
      else if (sync_o) sync_run_q <= sync_run_q + 1'b1;
      else             sync_run_q <= '0;
   end

   assert_sync_width_R2: assert property (@(posedge clk) disable iff (rst)
      $fell(sync_o) |-> (sync_run_q == SYNC_P));

   assert_sync_bound_R2: assert property (@(posedge clk) disable iff (rst)
      sync_o |-> (sync_run_q < SYNC_P));

   assert_sync_follows_start_R2: assert property (@(posedge clk) disable iff (rst)
      frame_start_o |=> sync_o);

   assert_sync_rise_R2: assert property (@(posedge clk) disable iff (rst)
      $rose(sync_o) |-> $past(frame_start_o));

   assert_reset_quiet_R7: assert property (@(posedge clk)
      rst |=> (!sync_o && !sdata_o));

   assert_idle_slot_zero_R5: assert property (@(posedge clk) disable iff (rst)
      ((hit & ~tag_q[NUM_SLOTS:1]) != '0) |=> !sdata_o);

   if (TAG_BITS > USED_TAG) begin : g_pad_check
      assert_tag_pad_R3: assert property (@(posedge clk) disable iff (rst)
         (emit_pos == POS_W'(TAG_BITS - 1)) |=> !sdata_o);
   end

endmodule

// File: tb/tdm_frame_tx_tb_top.sv
module tdm_frame_tx_tb_top;

   localparam int SLOTS = 12;
   localparam int SW    = 20;
   localparam int FB    = 256;

   logic clk = 1'b0;
   always #2 clk = ~clk;

   logic                rst;
   logic [SLOTS*SW-1:0] sd;
   logic [SLOTS-1:0]    sv;
   logic                fv;
   logic [1:0]          cid;
   logic                frame_start;
   logic                sync;
   logic                sdata;

   int  n_chk  = 0;
   int  n_fail = 0;
   bit  done   = 1'b0;

   tdm_frame_tx dut_i (
      .clk           (clk),
      .rst           (rst),
      .slot_data_i   (sd),
      .slot_valid_i  (sv),
      .frame_valid_i (fv),
      .codec_id_i    (cid),
      .frame_start_o (frame_start),
      .sync_o        (sync),
      .sdata_o       (sdata)
   );

   task automatic check(input bit ok, input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   function automatic logic [SLOTS*SW-1:0] gen_data(input logic [19:0] base);
      logic [SLOTS*SW-1:0] d;
      for (int k = 0; k < SLOTS; k++)
         d[k*SW +: SW] = base ^ (20'h13579 * 20'(k + 1));
      return d;
   endfunction

   task automatic wait_start();
      while (!frame_start) @(negedge clk);
   endtask

   // Sends one frame from the given inputs and checks every field of it.
   task automatic run_frame(input logic [SLOTS*SW-1:0] d, input logic [SLOTS-1:0] v,
                            input logic f, input logic [1:0] id, input bit perturb,
                            input string name);
      logic [FB-1:0]  got;
      logic [15:0]    tag_exp;
      logic [19:0]    gw;
      logic [19:0]    ew;
      int             sync_bad  = 0;
      int             start_bad = 0;
      int             bad_total = 0;
      wait_start();
      sd = d; sv = v; fv = f; cid = id;
      for (int k = 0; k <= FB; k++) begin
         @(posedge clk);
         @(negedge clk);
         if (perturb && k == 100) begin
            sd = ~d; sv = ~v; fv = ~f; cid = ~id;
         end
         if (sync !== ((k < 16) || (k == FB))) sync_bad++;
         if (k < FB && frame_start !== (k == FB - 1)) start_bad++;
         if (k >= 1) got[k-1] = sdata;
      end
      check(sync_bad == 0, "R2", {name, " marker pattern mismatches"}, sync_bad, 0);
      check(start_bad == 0, "R1", {name, " start strobe spacing mismatches"}, start_bad, 0);
      tag_exp = {1'b0, id[0], id[1], v, f};
      check(got[15:0] == tag_exp, "R3", {name, " tag slot"}, {16'h0, got[15:0]}, {16'h0, tag_exp});
      if (got[15:0] != tag_exp) bad_total++;
      check(got[16] == (v[0] & d[SW-1]), "R4", {name, " command bit F16"},
            {31'h0, got[16]}, {31'h0, v[0] & d[SW-1]});
      for (int s = 0; s < SLOTS; s++) begin
         for (int j = 0; j < SW; j++) gw[SW-1-j] = got[16 + SW*s + j];
         ew = v[s] ? d[s*SW +: SW] : 20'h0;
         check(gw == ew, v[s] ? "R4" : "R5", $sformatf("%s slot %0d", name, s + 1),
               {12'h0, gw}, {12'h0, ew});
         if (gw != ew) bad_total++;
      end
      if (perturb)
         check(bad_total == 0, "R6", {name, " fields disturbed by mid-frame change"},
               bad_total, 0);
   endtask

   task automatic test_reset_state();
      rst = 1'b1;
      sd = gen_data(20'hFFFFF); sv = '1; fv = 1'b1; cid = 2'b11;
      repeat (5) @(negedge clk);
      check(sync == 1'b0, "R7", "marker low in reset", {31'h0, sync}, 0);
      check(sdata == 1'b0, "R7", "data low in reset", {31'h0, sdata}, 0);
      check(frame_start == 1'b0, "R7", "strobe low in reset", {31'h0, frame_start}, 0);
      rst = 1'b0;
      #1;
      check(frame_start == 1'b1, "R1", "strobe in first cycle after reset",
            {31'h0, frame_start}, 1);
   endtask

   task automatic test_all_valid();
      run_frame(gen_data(20'hA5C3E), '1, 1'b1, 2'b01, 1'b0, "all-valid");
      run_frame(gen_data(20'h80001), '1, 1'b1, 2'b10, 1'b0, "all-valid-b");
   endtask

   task automatic test_sparse_valid();
      run_frame(gen_data(20'hFFFFF), 12'b1010_0101_0011, 1'b0, 2'b10, 1'b0, "sparse");
      run_frame(gen_data(20'h7B2D4), 12'b0000_0000_0000, 1'b1, 2'b11, 1'b0, "none-valid");
   endtask

   task automatic test_midframe_change();
      run_frame(gen_data(20'h3C96F), 12'b1111_0000_1111, 1'b1, 2'b01, 1'b1, "perturbed");
      run_frame(gen_data(20'h0F0F0), 12'b0110_1001_1110, 1'b0, 2'b00, 1'b0, "after-perturb");
   endtask

   task automatic test_reset_midframe();
      wait_start();
      repeat (40) @(negedge clk);
      rst = 1'b1;
      @(negedge clk);
      check(sync == 1'b0 && sdata == 1'b0, "R7", "outputs quiet after mid-frame reset",
            {30'h0, sync, sdata}, 0);
      check(frame_start == 1'b0, "R7", "strobe low during mid-frame reset",
            {31'h0, frame_start}, 0);
      repeat (2) @(negedge clk);
      rst = 1'b0;
      #1;
      check(frame_start == 1'b1, "R7", "counter cleared by reset", {31'h0, frame_start}, 1);
      run_frame(gen_data(20'h55AA5), 12'b1100_0011_0110, 1'b1, 2'b11, 1'b0, "post-reset");
   endtask

   initial begin
      #(4 * 200000);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL R1 watchdog expired: actual running expected finished");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      @(negedge clk);
      test_reset_state();
      test_all_valid();
      test_sparse_valid();
      test_midframe_change();
      test_reset_midframe();
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule